// File: doc/BRIEF.md
# Store Data Lane and Mask Generator

This unit turns a store request from the execute stage into the form a byte-addressable data memory accepts. The store size comes from the low two bits of the instruction's funct3 field. The target address may be unaligned. The source register value is the data. The unit drops the address's in-word offset to form a word address, moves the register data up into the byte lanes the offset selects, and raises one write-mask bit for each lane to be written. The incoming write request passes straight through.

The unit is purely combinational. All outputs settle in the same cycle as the inputs, so the memory can register address, data and mask together on the next edge. Alignment traps are raised elsewhere. When the unit meets a misaligned halfword, it still writes the halfword that contains the addressed byte.

Top module: `store_lane_unit`

## Requirements
- R1: `mem_addr_o` equals `st_addr_i` with its two lowest bits forced to zero, whatever the size and request.
- R2: `mem_req_o` equals `st_req_i` for every input combination.
- R3: Size code 2'b00 (byte) with the request high gives `mem_mask_o = 4'b0001 << st_addr_i[1:0]`. `mem_data_o` is `st_data_i` shifted left by 8 times `st_addr_i[1:0]` bits, zeros filling from below, so register bits 7:0 land in the addressed lane.
- R4: Size code 2'b01 (halfword) with the request high gives mask 4'b0011 when `st_addr_i[1]` is 0 and 4'b1100 when it is 1. Data is shifted left by 16 bits exactly when `st_addr_i[1]` is 1. `st_addr_i[0]` has no effect.
- R5: Size code 2'b10 (word) with the request high gives mask 4'b1111, and `mem_data_o` equals `st_data_i` for every offset.
- R6: With `st_req_i` low the mask is 4'b0000, while `mem_data_o` is still formed as in R3, R4, R5 and R8.
- R7: `st_funct3_i[2]` has no effect on any output.
- R8: The unused size code 2'b11 gives mask 4'b0000, and `mem_data_o` equals `st_data_i`.
- R9: Every output is a combinational function of the present inputs, valid in the same cycle the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_funct3_i | input | 3 | Store funct3; bits 1:0 select size, bit 2 ignored |
| st_addr_i | input | ADDR_W (32) | Byte address of the store, possibly unaligned |
| st_data_i | input | DATA_W (32) | Register value to store, in its low bits |
| st_req_i | input | 1 | Memory write requested this cycle |
| mem_addr_o | output | ADDR_W (32) | Word-aligned address |
| mem_data_o | output | DATA_W (32) | Data moved into its byte lanes |
| mem_mask_o | output | DATA_W/8 (4) | One write-enable bit per byte lane, bit 0 = lowest lane |
| mem_req_o | output | 1 | Write request to memory |

## Verification
The unit holds no state, so every result is due in the same cycle as the stimulus that caused it, with zero register stages between input and output. The bench applies each new input set just after a rising clock edge. It compares address, data, mask and request against its own model at the following falling edge, half a period later. No sample can therefore straddle two stimuli. The model runs over every size code, offset, request value and the ignored funct3 bit with several data patterns, and then over pseudo-random inputs.

// File: rtl/store_lane_pkg.sv
// Package: shared size encoding for the store lane unit.
// Assumes funct3[1:0] carries log2 of the store size in bytes.
package store_lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } st_size_e;

    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/stl_addr_align.sv
// Module: stl_addr_align
// Splits a byte address into a word-aligned address and the in-word
// byte offset. Assumes OFF_W >= 1 (at least two byte lanes).
module stl_addr_align #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic [OFF_W-1:0]  offset_o
);
    // Clear the offset bits and expose them separately.
    always_comb begin
        word_addr_o = {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        offset_o    = addr_i[OFF_W-1:0];
    end
endmodule

// File: rtl/stl_size_decode.sv
// Module: stl_size_decode
// Turns the size code and byte offset into the first lane of the access
// (offset rounded down to the access size) and a legality flag. A size
// wider than the data word is illegal and yields base lane zero.
module stl_size_decode #(
    parameter int unsigned OFF_W = 2
) (
    input  store_lane_pkg::st_size_e size_i,
    input  logic [OFF_W-1:0]         offset_i,
    output logic [OFF_W-1:0]         base_o,
    output logic                     legal_o
);
    // Keep offset bits at or above the size; clear the ones below it.
    always_comb begin
        legal_o = (int'(size_i) <= int'(OFF_W));
        for (int b = 0; b < int'(OFF_W); b++) begin
            base_o[b] = legal_o && (b >= int'(size_i)) ? offset_i[b] : 1'b0;
        end
    end
endmodule

// File: rtl/stl_mask_gen.sv
// Module: stl_mask_gen
// Produces one write-enable bit per byte lane. A lane is enabled when it
// shares the access-size-aligned block with the addressed byte, the size
// is legal and a write is requested.
module stl_mask_gen #(
    parameter int unsigned LANES = 4,
    parameter int unsigned OFF_W = 2
) (
    input  store_lane_pkg::st_size_e size_i,
    input  logic [OFF_W-1:0]         offset_i,
    input  logic                     legal_i,
    input  logic                     req_i,
    output logic [LANES-1:0]         mask_o
);
    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(g);
        // Compare lane and offset after dropping the bits inside the access.
        always_comb begin
            mask_o[g] = req_i && legal_i &&
                        ((LANE_IDX >> size_i) == (offset_i >> size_i));
        end
    end
endmodule

// File: rtl/stl_lane_shift.sv
// Module: stl_lane_shift
// Moves the register data up by base_i byte lanes; lanes below the base
// are filled with zeros. Base zero passes the data unchanged.
module stl_lane_shift #(
    parameter int unsigned LANES = 4,
    parameter int unsigned OFF_W = 2
) (
    input  logic [LANES*8-1:0] data_i,
    input  logic [OFF_W-1:0]   base_i,
    output logic [LANES*8-1:0] data_o
);
    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(g);
        logic [OFF_W-1:0] src_idx;
        // Pick the source byte that lands in this lane, or zero below the base.
        always_comb begin
            src_idx = LANE_IDX - base_i;
            data_o[g*8 +: 8] = (LANE_IDX >= base_i) ? data_i[src_idx*8 +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/store_lane_unit.sv
// Module: store_lane_unit (top)
// Combinational store formatter: word address, lane-shifted data, byte
// mask and pass-through request. funct3[2] is ignored. Assumes DATA_W is
// a power-of-two multiple of 8, at least 16.
module store_lane_unit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic [2:0]               st_funct3_i,
    input  logic [ADDR_W-1:0]        st_addr_i,
    input  logic [DATA_W-1:0]        st_data_i,
    input  logic                     st_req_i,
    output logic [ADDR_W-1:0]        mem_addr_o,
    output logic [DATA_W-1:0]        mem_data_o,
    output logic [DATA_W/8-1:0]      mem_mask_o,
    output logic                     mem_req_o
);
    import store_lane_pkg::*;

    localparam int unsigned LANES = DATA_W / BYTE_W;
    localparam int unsigned OFF_W = $clog2(LANES);

    st_size_e         size_code;
    logic [OFF_W-1:0] byte_off;
    logic [OFF_W-1:0] base_lane;
    logic             size_legal;
    logic             unused_sign_sel;

    // Size comes from funct3[1:0]; bit 2 only selects load signedness.
    always_comb begin
        size_code       = st_size_e'(st_funct3_i[1:0]);
        unused_sign_sel = st_funct3_i[2];
    end

    stl_addr_align #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_align (
        .addr_i      (st_addr_i),
        .word_addr_o (mem_addr_o),
        .offset_o    (byte_off)
    );

    stl_size_decode #(.OFF_W(OFF_W)) u_size (
        .size_i   (size_code),
        .offset_i (byte_off),
        .base_o   (base_lane),
        .legal_o  (size_legal)
    );

    stl_mask_gen #(.LANES(LANES), .OFF_W(OFF_W)) u_mask (
        .size_i   (size_code),
        .offset_i (byte_off),
        .legal_i  (size_legal),
        .req_i    (st_req_i),
        .mask_o   (mem_mask_o)
    );

    stl_lane_shift #(.LANES(LANES), .OFF_W(OFF_W)) u_shift (
        .data_i (st_data_i),
        .base_i (base_lane),
        .data_o (mem_data_o)
    );

    // The request is forwarded untouched.
    always_comb mem_req_o = st_req_i;
endmodule

// File: rtl/store_lane_unit_chk.sv
// Module: store_lane_unit_chk
// Port-level checks for store_lane_unit, attached by bind. The block is
// combinational, so the checks are immediate and re-evaluated whenever
// an input or output moves.
module store_lane_unit_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic [2:0]          st_funct3_i,
    input logic [ADDR_W-1:0]   st_addr_i,
    input logic [DATA_W-1:0]   st_data_i,
    input logic                st_req_i,
    input logic [ADDR_W-1:0]   mem_addr_o,
    input logic [DATA_W-1:0]   mem_data_o,
    input logic [DATA_W/8-1:0] mem_mask_o,
    input logic                mem_req_o
);
    localparam int unsigned LANES = DATA_W / 8;
    localparam int unsigned OFF_W = $clog2(LANES);

    logic unused_chk;
    always_comb unused_chk = ^{st_funct3_i[2], st_data_i, mem_data_o};

    // Relate outputs to inputs at the ports.
    always_comb begin
        AST_ADDR_WORD_ALIGNED: assert (mem_addr_o[OFF_W-1:0] == '0 &&
            mem_addr_o[ADDR_W-1:OFF_W] == st_addr_i[ADDR_W-1:OFF_W]) else $error("addr"); // R1
        AST_REQ_FORWARDED: assert (mem_req_o == st_req_i) else $error("req"); // R2
        if (!st_req_i) begin
            AST_IDLE_NO_MASK: assert (mem_mask_o == '0) else $error("idle mask"); // R6
        end
        if (st_req_i && st_funct3_i[1:0] == 2'b00) begin
            AST_BYTE_ONE_LANE: assert ($countones(mem_mask_o) == 1) else $error("byte"); // R3
        end
        if (st_req_i && st_funct3_i[1:0] == 2'b01) begin
            AST_HALF_TWO_LANES: assert ($countones(mem_mask_o) == 2) else $error("half"); // R4
        end
        if (st_req_i && st_funct3_i[1:0] == 2'b10) begin
            AST_WORD_ALL_LANES: assert (&mem_mask_o) else $error("word"); // R5
        end
        if (st_funct3_i[1:0] == 2'b11) begin
            AST_RSVD_NO_MASK: assert (mem_mask_o == '0) else $error("rsvd"); // R8
        end
    end
endmodule

bind store_lane_unit store_lane_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .st_funct3_i (st_funct3_i),
    .st_addr_i   (st_addr_i),
    .st_data_i   (st_data_i),
    .st_req_i    (st_req_i),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .mem_mask_o  (mem_mask_o),
    .mem_req_o   (mem_req_o)
);

// File: tb/store_lane_unit_tb_top.sv
// Bench for store_lane_unit: a behavioural model computes the expected
// outputs; inputs change just after a rising edge and outputs are compared
// at the next falling edge (R9: zero register stages).
module store_lane_unit_tb_top;
    logic        clk = 1'b0;
    logic [2:0]  f3;
    logic [31:0] addr;
    logic [31:0] data;
    logic        req;
    logic [31:0] o_addr;
    logic [31:0] o_data;
    logic [3:0]  o_mask;
    logic        o_req;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;  // 50 MHz

    store_lane_unit dut_i (
        .st_funct3_i (f3),
        .st_addr_i   (addr),
        .st_data_i   (data),
        .st_req_i    (req),
        .mem_addr_o  (o_addr),
        .mem_data_o  (o_data),
        .mem_mask_o  (o_mask),
        .mem_req_o   (o_req)
    );

    // Report one comparison.
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (f3=%0d addr=%h data=%h req=%0b)",
                     tag, act, exp, f3, addr, data, req);
        end
    endtask

    // Apply one input set and compare against the model half a period later.
    task automatic apply(logic [2:0] f, logic [31:0] a, logic [31:0] d, logic r);
        int nbytes;
        int off;
        logic [3:0]  e_mask;
        logic [31:0] e_data;
        string       tag;
        @(posedge clk);
        #1;
        f3 = f; addr = a; data = d; req = r;
        // Model: size in bytes, offset rounded down to it, plain shifts.
        if (f[1:0] == 2'b11) begin
            e_mask = 4'b0000;
            e_data = d;
            tag = "R8";
        end else begin
            nbytes = 1 << f[1:0];
            off    = (int'(a[1:0]) / nbytes) * nbytes;
            e_mask = 4'(((1 << nbytes) - 1) << off);
            e_data = d << (8 * off);
            tag = (f[1:0] == 2'b00) ? "R3" : (f[1:0] == 2'b01) ? "R4" : "R5";
        end
        if (!r) begin
            e_mask = 4'b0000;
            tag = "R6";
        end
        if (f[2]) tag = {tag, "/R7"};
        @(negedge clk);
        check("R1 addr", o_addr, {a[31:2], 2'b00});
        check("R2 req", {31'b0, o_req}, {31'b0, r});
        check({tag, " mask"}, {28'b0, o_mask}, {28'b0, e_mask});
        check({tag, " data"}, o_data, e_data);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'hA1B2C3D4;
        pats[1] = 32'h000000FF;
        pats[2] = 32'hFFFF8001;
        pats[3] = 32'h12345678;
        f3 = 3'd0; addr = '0; data = '0; req = 1'b0;
        // Quiet state: no request, no mask (R6, R2).
        @(negedge clk);
        check("R6 idle mask", {28'b0, o_mask}, 32'h0);
        check("R2 idle req", {31'b0, o_req}, 32'h0);
        // Every size code, offset, request and sign bit (R3..R8).
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 8; f++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int r = 0; r < 2; r++) begin
                        apply(3'(f), {28'h8000_123, 2'b01, 2'(o)}, pats[p], 1'(r));
                    end
                end
            end
        end
        // Explicit corners: halfword at odd offsets ignores bit 0 (R4).
        apply(3'b001, 32'h0000_0003, 32'hCAFE_BEEF, 1'b1);
        apply(3'b001, 32'h0000_0001, 32'hCAFE_BEEF, 1'b1);
        // Word store at an unaligned address keeps data unshifted (R5).
        apply(3'b010, 32'hFFFF_FFFF, 32'h0BAD_F00D, 1'b1);
        // Pseudo-random sweep.
        for (int i = 0; i < 400; i++) begin
            apply(3'($urandom), $urandom, $urandom, 1'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule